// File: doc/BRIEF.md
# Store Write Buffer with Youngest-Match Load Forwarding

This block holds committed stores between the store execution path and the data memory. A store lands in a small circular queue rather than in memory. The queue presents its oldest pending store on a drain port, and memory accepts it with a handshake. Entries therefore reach memory in program order, one per accepted handshake.

Loads present an address to a combinational lookup port. Because the queued stores are newer than anything memory holds, the lookup searches every occupied entry. When more than one entry matches, the most recently written one supplies the data. A miss tells the load path to use the memory value instead.

The result is that drained memory, overlaid with the pending entries, always reads back exactly what a memory written directly by every store would hold.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `st_ready`=1, `dr_valid`=0, `ld_hit`=0.
- R2: An accepted store is written only into the queue, never to memory. Memory is changed only by drain handshakes, and stores drain in acceptance order, oldest first.
- R3: With four stores pending, `st_ready` is 0. A store offered while full is ignored: it never appears on the drain port.
- R4: `dr_valid` is 1 exactly when at least one store is pending. `dr_addr`/`dr_data` show the oldest pending store. The head advances only in a cycle where `dr_valid` and `dr_ready` are both 1.
- R5: While `dr_valid`=1 and `dr_ready`=0, `dr_addr` and `dr_data` stay unchanged into the next cycle.
- R6: `ld_hit`=1 when any pending entry's address equals `ld_addr`. `ld_data` then comes from the youngest such entry.
- R7: When no pending entry matches, `ld_hit`=0 and `ld_data`=0.
- R8: A store and a drain can both complete in the same cycle. The occupancy is then unchanged and the order is kept.
- R9: For every address, taking the youngest matching pending entry, or the memory word when none matches, gives the value a directly written memory holds.
- R10: The lookup reflects entries that existed before the current clock edge. A store offered in the same cycle as a load is not yet visible to that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A pending store matches the load |
| ld_data | output | DW | Forwarded data from the youngest match |
| dr_valid | output | 1 | Oldest pending store is offered to memory |
| dr_ready | input | 1 | Memory accepts the offered store |
| dr_addr | output | AW | Address of the offered store |
| dr_data | output | DW | Data of the offered store |

## Verification
The assertions assume that the store side drops a request when `st_ready` is low and that memory honours a drain only when it returns `dr_ready` in that cycle. The occupancy they track is therefore rebuilt from the two port handshakes alone. Stimulus sets every input just after the falling edge and keeps addresses inside an eight-word window, so that repeated addresses and youngest-match selection happen often. The bench's reference memory lives in that same window.

// File: rtl/wbuf_pkg.sv
// Shared types for the store write buffer.
// Assumes nothing beyond a two-bit encoding of the queue operation.
package wbuf_pkg;
    // Queue update selected in one cycle: {push, pop}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } wb_op_e;
endpackage

// File: rtl/wbuf_ctrl.sv
// Queue control: head/tail pointers, occupancy and handshake decisions.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             dr_ready,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             st_ready,
    output logic             dr_valid,
    output logic             push,
    output logic             pop
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE_PTR  = PTR_W'(1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    wb_op_e op;

    // Decide readiness and which handshakes complete this cycle
    always_comb begin
        st_ready = (count != FULL_CNT);
        dr_valid = (count != '0);
        push     = st_valid && st_ready;
        pop      = dr_valid && dr_ready;
        op       = wb_op_e'({push, pop});
    end

    // Advance pointers and occupancy according to the selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    tail  <= tail + ONE_PTR;
                    count <= count + ONE_CNT;
                end
                OP_POP: begin
                    head  <= head + ONE_PTR;
                    count <= count - ONE_CNT;
                end
                OP_BOTH: begin
                    tail  <= tail + ONE_PTR;
                    head  <= head + ONE_PTR;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wbuf_store.sv
// Entry storage: one address/data/valid slot per queue position.
// Assumes push and pop never target the same slot in one cycle, which the
// controller guarantees (same slot only when empty or full).
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic                      pop,
    input  logic [PTR_W-1:0]          wr_idx,
    input  logic [PTR_W-1:0]          rd_idx,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [DEPTH-1:0][AW-1:0]  ent_addr,
    output logic [DEPTH-1:0][DW-1:0]  ent_data,
    output logic [DEPTH-1:0]          ent_valid
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT = PTR_W'(i);

        // Fill the slot on a store at the tail, free it when drained
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_addr[i]  <= '0;
                ent_data[i]  <= '0;
            end else if (push && (wr_idx == SLOT)) begin
                ent_valid[i] <= 1'b1;
                ent_addr[i]  <= wr_addr;
                ent_data[i]  <= wr_data;
            end else if (pop && (rd_idx == SLOT)) begin
                ent_valid[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wbuf_fwd.sv
// Load lookup: compares every valid slot with the load address and picks
// the youngest match by walking slots from head (oldest) to newest.
// Assumes DEPTH is a power of two.
module wbuf_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]  ent_data,
    input  logic [DEPTH-1:0]          ent_valid,
    input  logic [PTR_W-1:0]          head,
    input  logic [AW-1:0]             ld_addr,
    output logic                      ld_hit,
    output logic [DW-1:0]             ld_data
);
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] slot;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // Per-slot address compare, gated by occupancy
        assign match[i] = ent_valid[i] && (ent_addr[i] == ld_addr);
    end

    // Age-ordered scan: a later (younger) match overrides an earlier one
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        slot    = head;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + PTR_W'(k);
            if (match[slot]) begin
                ld_hit  = 1'b1;
                ld_data = ent_data[slot];
            end
        end
    end
endmodule

// File: rtl/wbuf_top.sv
// Store write buffer top: queues stores, drains them in order to memory
// and forwards the youngest matching pending store to loads.
// Assumes memory takes a drain only when it drives dr_ready in that cycle.
module wbuf_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          dr_valid,
    input  logic          dr_ready,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [PTR_W-1:0]         head;
    logic [PTR_W-1:0]         tail;
    logic [CNT_W-1:0]         count;
    logic                     push;
    logic                     pop;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0]         ent_valid;

    wbuf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .dr_ready (dr_ready),
        .head     (head),
        .tail     (tail),
        .count    (count),
        .st_ready (st_ready),
        .dr_valid (dr_valid),
        .push     (push),
        .pop      (pop)
    );

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_idx    (tail),
        .rd_idx    (head),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_valid (ent_valid)
    );

    wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PTR_W(PTR_W)) u_fwd (
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_valid (ent_valid),
        .head      (head),
        .ld_addr   (ld_addr),
        .ld_hit    (ld_hit),
        .ld_data   (ld_data)
    );

    // Present the oldest entry on the drain port
    always_comb begin
        dr_addr = ent_addr[head];
        dr_data = ent_data[head];
    end
endmodule

// File: rtl/wbuf_chk.sv
// Protocol checker for wbuf_top. It rebuilds the occupancy from the port
// handshakes and compares that against the outputs and the slot valid bits.
module wbuf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_ready,
    input logic             dr_valid,
    input logic             dr_ready,
    input logic [AW-1:0]    dr_addr,
    input logic [DW-1:0]    dr_data,
    input logic             ld_hit,
    input logic [DEPTH-1:0] ent_valid
);
    int sh;

    // Shadow occupancy built from the handshakes alone
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= 0;
        else sh <= sh + ((st_valid && st_ready) ? 1 : 0) - ((dr_valid && dr_ready) ? 1 : 0);
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dr_valid && st_ready && !ld_hit)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sh <= DEPTH); // R3
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready == (sh < DEPTH)); // R3
    AST_DRAIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid == (sh != 0)); // R4
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data))); // R5
    AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (sh == 0) |-> !ld_hit); // R7
    AST_SLOTS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_valid) == sh); // R2
endmodule

bind wbuf_top wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .dr_valid  (dr_valid),
    .dr_ready  (dr_ready),
    .dr_addr   (dr_addr),
    .dr_data   (dr_data),
    .ld_hit    (ld_hit),
    .ent_valid (ent_valid)
);

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
// Bench for wbuf_top: directed corners, then seeded random traffic, all
// checked against a queue model, a drained memory and a direct memory.
module sim_wbuf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [15:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [15:0] ld_addr = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        dr_valid;
    logic        dr_ready = 1'b0;
    logic [15:0] dr_addr;
    logic [31:0] dr_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int          qn = 0;
    logic [15:0] qa [4];
    logic [31:0] qd [4];
    logic [31:0] mem  [8];
    logic [31:0] refm [8];

    always #2.5 clk = ~clk;

    wbuf_top u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [15:0] a);
        exp_hit = 0;
        for (int k = 0; k < qn; k++) if (qa[k] == a) exp_hit = 1;
    endfunction

    function automatic logic [31:0] exp_data(input logic [15:0] a);
        exp_data = '0;
        for (int k = 0; k < qn; k++) if (qa[k] == a) exp_data = qd[k];
    endfunction

    // One cycle: check settled outputs, then apply handshakes to the models
    task automatic step();
        bit sf, df;
        logic [31:0] seen;
        #1;
        chk(st_ready == (qn < 4), "R3 st_ready", 32'(st_ready), 32'(qn < 4));
        chk(dr_valid == (qn > 0), "R4 dr_valid", 32'(dr_valid), 32'(qn > 0));
        if (qn > 0) begin
            chk(dr_addr == qa[0], "R4 dr_addr oldest", 32'(dr_addr), 32'(qa[0]));
            chk(dr_data == qd[0], "R4 dr_data oldest", dr_data, qd[0]);
        end
        chk(ld_hit == exp_hit(ld_addr), "R6 ld_hit", 32'(ld_hit), 32'(exp_hit(ld_addr)));
        chk(ld_data == exp_data(ld_addr), "R6/R7 ld_data", ld_data, exp_data(ld_addr));
        if (ld_addr < 16'd8) begin
            seen = ld_hit ? ld_data : mem[ld_addr[2:0]];
            chk(seen == refm[ld_addr[2:0]], "R9 merged view", seen, refm[ld_addr[2:0]]);
        end
        sf = st_valid && (qn < 4);
        df = dr_ready && (qn > 0);
        @(posedge clk);
        if (df) begin
            mem[qa[0][2:0]] = qd[0];
            for (int k = 0; k < 3; k++) begin qa[k] = qa[k+1]; qd[k] = qd[k+1]; end
            qn--;
        end
        if (sf) begin
            qa[qn] = st_addr; qd[qn] = st_data; qn++;
            refm[st_addr[2:0]] = st_data;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        st_valid = 0; dr_ready = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] a0;
        logic [31:0] d0;
        void'($urandom(32'd11));
        for (int k = 0; k < 8; k++) begin mem[k] = '0; refm[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: empty after reset
        chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 1);
        chk(dr_valid == 1'b0, "R1 dr_valid", 32'(dr_valid), 0);
        chk(ld_hit == 1'b0, "R1 ld_hit", 32'(ld_hit), 0);
        @(negedge clk);

        // R2/R3: fill four stores, two to the same address, no drain
        for (int i = 0; i < 4; i++) begin
            st_valid = 1; st_addr = (i == 3) ? 16'd2 : 16'(i + 1); st_data = 32'hA000 + 32'(i);
            ld_addr = 16'd2;
            step();
        end
        st_valid = 0; #1;
        chk(dr_addr == 16'd1, "R2 first store drains first", 32'(dr_addr), 1);
        chk(mem[1] == 32'h0, "R2 memory untouched", mem[1], 0);
        chk(st_ready == 1'b0, "R3 full not ready", 32'(st_ready), 0);
        // R6: youngest of two address-2 stores
        chk(ld_hit && ld_data == 32'hA003, "R6 youngest match", ld_data, 32'hA003);
        @(negedge clk);
        // R3: offer a fifth store while full; it must be dropped
        st_valid = 1; st_addr = 16'd7; st_data = 32'hDEAD;
        step();
        st_valid = 0;
        ld_addr = 16'd7; #1;
        chk(ld_hit == 1'b0, "R3 dropped store invisible", 32'(ld_hit), 0);
        @(negedge clk);
        // R5: hold while memory stalls
        a0 = dr_addr; d0 = dr_data;
        repeat (3) step();
        chk(dr_addr == a0 && dr_data == d0, "R5 drain held", dr_data, d0);
        // R4: drain two
        dr_ready = 1; step(); step();
        // R8: store and drain in one cycle with two pending
        st_valid = 1; st_addr = 16'd5; st_data = 32'hBEEF; dr_ready = 1;
        step();
        idle(); #1;
        chk(st_ready == 1'b1 && dr_addr == 16'd2, "R8 order kept after simultaneous ops", 32'(dr_addr), 2);
        @(negedge clk);
        // R10: load to the address being stored this cycle sees nothing yet
        st_valid = 1; st_addr = 16'd6; st_data = 32'h6666; ld_addr = 16'd6; #1;
        chk(ld_hit == 1'b0, "R10 same-cycle store not visible", 32'(ld_hit), 0);
        step();
        st_valid = 0; #1;
        chk(ld_hit == 1'b1 && ld_data == 32'h6666, "R10 visible next cycle", ld_data, 32'h6666);
        @(negedge clk);
        // R7: miss returns zero
        ld_addr = 16'd0; #1;
        chk(ld_hit == 1'b0 && ld_data == 32'h0, "R7 miss", ld_data, 0);
        @(negedge clk);

        // Random phase (R2, R4, R6, R8, R9)
        for (int c = 0; c < 600; c++) begin
            st_valid = ($urandom % 3) != 0;
            st_addr  = 16'($urandom % 8);
            st_data  = $urandom;
            dr_ready = ($urandom % 2) != 0;
            ld_addr  = 16'($urandom % 9);
            step();
        end
        // Drain out and compare the whole memory (R9)
        idle(); dr_ready = 1;
        repeat (6) step();
        for (int k = 0; k < 8; k++)
            chk(mem[k] == refm[k], "R9 drained memory", mem[k], refm[k]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule